// File: doc/BRIEF.md
# Fractional Audio Bit-Clock Generator

This block derives an audio bit clock from one of several source clocks. Each source reaches the block as a one-cycle tick on the system clock, one tick per source edge. The block divides the chosen source by a ratio that has a 12-bit integer part and a 12-bit fractional part. When first-order noise shaping is selected, a 12-bit phase accumulator gains the fraction once per output period. Each carry out of the accumulator makes that period one source tick longer, so the long-run average ratio equals integer + fraction/4096. With shaping off, the fraction has no effect and the divide is a plain integer one.

Software uses two 32-bit registers: a control word and a divisor word. A write lands only if its top byte carries the key value 0x5A. Clearing the enable does not stop the clock at once. The busy flag stays set until the current output period has completed and the output has parked at its idle level. A kill bit stops the output without waiting for a clean edge. The source, shaping order and divisor fields are frozen while busy is set. The output is registered and can be inverted.

Top module: `frac_clkgen`

## Requirements
- R1: A write whose bits 31:24 differ from 0x5A leaves both registers unchanged.
- R2: Control word fields: source select 3:0, enable 4, kill 5, busy 7 (read-only), invert 8, shaping order 10:9. Divisor word fields: integer 23:12, fraction 11:0. Bits outside these fields read as 0, and every field reads 0 after reset.
- R3: Source select 0 (ground) and any value of 8 or more give no clock. A value of 1 to 7 counts only the ticks of that source.
- R4: With shaping order 0, the fraction is ignored and the output period is exactly the integer divisor N ticks. The output is high for floor(N/2) ticks of each period and falls at the period boundary.
- R5: An integer divisor of 0 or 1 acts as 2.
- R6: With a nonzero shaping order, the fraction is added to a 12-bit accumulator once per period, and a carry stretches that period by one tick. For divisor 4, any 8 consecutive periods total 34 ticks at fraction 0x400 and 36 ticks at fraction 0x800.
- R7: After enable is cleared, busy stays 1 until the output completes its high phase. Busy then drops on the same clock edge as the output's final fall, and the output stays at its idle level.
- R8: Setting kill brings busy to 0 and the output to its idle level within two clock edges of the write, whatever the phase. Both stay there while kill is set.
- R9: While busy is 1, writes to the source, order and divisor fields are ignored. Enable, kill and invert are still accepted.
- R10: The invert bit flips the output polarity, including the idle level.
- R11: A control write that leaves enable 1 and kill 0 while idle sets busy on the second clock edge after the write.
- R12: While running, the output changes only on a tick of the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | NUM_SRC | One-cycle edge ticks, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 divisor |
| wr_data | input | 32 | Write value, key in bits 31:24 |
| rd_sel | input | 1 | Read target: 0 control, 1 divisor |
| rd_data | output | 32 | Read value of the selected register |
| clk_out | output | 1 | Registered bit clock |

## Verification
The bench builds the block with NUM_SRC = 8. This makes select value 0 (a grounded input whose tick line is held high) and select value 9 (beyond the last source) both reachable, and both must stay silent. Sources run at different tick rates: every cycle, every third cycle, and every second cycle. Period lengths measured in system cycles therefore show which source is counted. Fractions 0x400 and 0x800 on divisor 4 give short, exactly predictable carry patterns. Odd divisors and an inverted output separate the high-phase and low-phase lengths.

// File: rtl/frac_clkgen_pkg.sv
package frac_clkgen_pkg;
    localparam int SEL_W = 4;
    localparam int ORD_W = 2;
    localparam int INT_W = 12;
    localparam int FRAC_W = 12;
    localparam logic [7:0] WR_KEY = 8'h5A;

    // control word bit positions
    localparam int CB_SRC = 0;
    localparam int CB_EN = 4;
    localparam int CB_KILL = 5;
    localparam int CB_BUSY = 7;
    localparam int CB_INV = 8;
    localparam int CB_ORD = 9;
    // divisor word bit positions
    localparam int DB_FRAC = 0;
    localparam int DB_INT = 12;

    typedef struct packed {
        logic [SEL_W-1:0]  src;
        logic              enab;
        logic              kill;
        logic              inv;
        logic [ORD_W-1:0]  order;
        logic [INT_W-1:0]  divi;
        logic [FRAC_W-1:0] divf;
    } cfg_t;
endpackage

// File: rtl/frac_clkgen_regs.sv
module frac_clkgen_regs
    import frac_clkgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    input  logic        busy,
    output cfg_t        cfg
);
    cfg_t cfg_d, cfg_q;
    logic key_ok;

    always_comb begin
        cfg_d  = cfg_q;
        key_ok = (wr_data[31:24] == WR_KEY);
        if (wr_en && key_ok) begin
            if (!wr_sel) begin
                cfg_d.enab = wr_data[CB_EN];
                cfg_d.kill = wr_data[CB_KILL];
                cfg_d.inv  = wr_data[CB_INV];
                if (!busy) begin
                    cfg_d.src   = wr_data[CB_SRC +: SEL_W];
                    cfg_d.order = wr_data[CB_ORD +: ORD_W];
                end
            end else if (!busy) begin
                cfg_d.divi = wr_data[DB_INT +: INT_W];
                cfg_d.divf = wr_data[DB_FRAC +: FRAC_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/frac_clkgen_srcmux.sv
module frac_clkgen_srcmux #(
    parameter int NUM_SRC = 8,
    parameter int SEL_W   = 4
) (
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick
);
    logic [NUM_SRC-1:0] gated;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (g == 0) begin : g_ground
            // input 0 is ground: its tick line never counts
            assign gated[g] = src_tick[g] & 1'b0;
        end else begin : g_live
            assign gated[g] = src_tick[g] & (sel == SEL_W'(g));
        end
    end

    assign tick = |gated;
endmodule

// File: rtl/frac_clkgen_core.sv
module frac_clkgen_core #(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enab,
    input  logic              kill,
    input  logic              inv,
    input  logic              shape_on,
    input  logic [INT_W-1:0]  divi,
    input  logic [FRAC_W-1:0] divf,
    output logic              running,
    output logic              clk_out
);
    localparam int PER_W = INT_W + 1;

    typedef struct packed {
        logic              running;
        logic              gen;
        logic              out;
        logic [PER_W-1:0]  cnt;
        logic [PER_W-1:0]  per;
        logic [FRAC_W-1:0] acc;
    } st_t;

    st_t st_d, st_q;
    logic [PER_W-1:0]  base;
    logic [FRAC_W-1:0] frac;
    logic [FRAC_W:0]   sum;
    logic [PER_W-1:0]  low_len;
    logic [PER_W-1:0]  cnt_nx;

    always_comb begin
        base    = (divi < INT_W'(2)) ? PER_W'(2) : {1'b0, divi};
        frac    = shape_on ? divf : '0;
        sum     = {1'b0, st_q.acc} + {1'b0, frac};
        low_len = st_q.per - (st_q.per >> 1);
        cnt_nx  = st_q.cnt + PER_W'(1);
        st_d    = st_q;
        if (kill) begin
            st_d.running = 1'b0;
            st_d.gen     = 1'b0;
            st_d.cnt     = '0;
            st_d.acc     = '0;
        end else if (!st_q.running) begin
            if (enab) begin
                st_d.running = 1'b1;
                st_d.gen     = 1'b0;
                st_d.cnt     = '0;
                st_d.per     = base;
                st_d.acc     = frac;
            end
        end else if (tick) begin
            if (st_q.cnt == st_q.per - PER_W'(1)) begin
                // period boundary: output falls, accumulator steps
                st_d.cnt = '0;
                st_d.gen = 1'b0;
                st_d.acc = sum[FRAC_W-1:0];
                st_d.per = base + {{(PER_W-1){1'b0}}, sum[FRAC_W]};
                if (!enab) st_d.running = 1'b0;
            end else begin
                st_d.cnt = cnt_nx;
                st_d.gen = (cnt_nx >= low_len);
            end
        end
        st_d.out = st_d.gen ^ inv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running = st_q.running;
    assign clk_out = st_q.out;
endmodule

// File: rtl/frac_clkgen.sv
module frac_clkgen
    import frac_clkgen_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [31:0]        wr_data,
    input  logic               rd_sel,
    output logic [31:0]        rd_data,
    output logic               clk_out
);
    cfg_t cfg;
    logic tick_sel;
    logic busy_w;
    logic cfg_enab, cfg_kill, cfg_inv;
    logic [SEL_W-1:0] cfg_src;
    logic [ORD_W-1:0] cfg_order;
    logic [INT_W+FRAC_W-1:0] div_word;

    assign cfg_enab  = cfg.enab;
    assign cfg_kill  = cfg.kill;
    assign cfg_inv   = cfg.inv;
    assign cfg_src   = cfg.src;
    assign cfg_order = cfg.order;
    assign div_word  = {cfg.divi, cfg.divf};

    frac_clkgen_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .busy    (busy_w),
        .cfg     (cfg)
    );

    frac_clkgen_srcmux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
        .src_tick (src_tick),
        .sel      (cfg_src),
        .tick     (tick_sel)
    );

    frac_clkgen_core #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_sel),
        .enab     (cfg_enab),
        .kill     (cfg_kill),
        .inv      (cfg_inv),
        .shape_on (|cfg_order),
        .divi     (cfg.divi),
        .divf     (cfg.divf),
        .running  (busy_w),
        .clk_out  (clk_out)
    );

    always_comb begin
        rd_data = '0;
        if (rd_sel) begin
            rd_data[DB_INT +: INT_W]   = cfg.divi;
            rd_data[DB_FRAC +: FRAC_W] = cfg.divf;
        end else begin
            rd_data[CB_SRC +: SEL_W] = cfg_src;
            rd_data[CB_EN]           = cfg_enab;
            rd_data[CB_KILL]         = cfg_kill;
            rd_data[CB_BUSY]         = busy_w;
            rd_data[CB_INV]          = cfg_inv;
            rd_data[CB_ORD +: ORD_W] = cfg_order;
        end
    end
endmodule

// File: rtl/frac_clkgen_chk.sv
module frac_clkgen_chk
    import frac_clkgen_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic                    wr_sel,
    input logic [31:0]             wr_data,
    input logic                    tick,
    input logic                    enab,
    input logic                    kill,
    input logic                    inv,
    input logic [SEL_W-1:0]        src_sel,
    input logic [ORD_W-1:0]        order,
    input logic [INT_W+FRAC_W-1:0] div_word,
    input logic                    running,
    input logic                    clk_out
);
    a_r1_bad_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] != WR_KEY) |=>
            ($stable(div_word) && $stable({src_sel, enab, kill, inv, order})));

    a_r9_divisor_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && running) |=> $stable(div_word));

    a_r9_source_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && running) |=> ($stable(src_sel) && $stable(order)));

    a_r8_kill_stops: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !running);

    a_r7_parks_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(running) && $stable(inv)) |-> (clk_out == inv));

    a_r11_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && enab && !kill) |=> running);

    a_r12_edge_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick && !kill && $stable(inv)) |=> $stable(clk_out));
endmodule

bind frac_clkgen frac_clkgen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .tick     (tick_sel),
    .enab     (cfg_enab),
    .kill     (cfg_kill),
    .inv      (cfg_inv),
    .src_sel  (cfg_src),
    .order    (cfg_order),
    .div_word (div_word),
    .running  (busy_w),
    .clk_out  (clk_out)
);

// File: tb/sim_frac_clkgen.sv
module sim_frac_clkgen;
    import frac_clkgen_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSRC-1:0] src_tick = '0;
    logic wr_en = 1'b0;
    logic wr_sel = 1'b0;
    logic rd_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic clk_out;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_clkgen #(.NUM_SRC(NSRC)) u0 (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .clk_out(clk_out)
    );

    // source 0 and 1 tick every cycle, 2 every third cycle, others every second
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 6;
            src_tick[0] = 1'b1;
            src_tick[1] = 1'b1;
            src_tick[2] = (ph % 3 == 0);
            for (int k = 3; k < NSRC; k++) src_tick[k] = (ph % 2 == 0);
        end
    end

    function automatic logic [31:0] ctl_w(input logic [3:0] src, input logic en,
                                          input logic kill, input logic inv,
                                          input logic [1:0] ord);
        return {WR_KEY, 13'd0, ord, inv, 2'b00, kill, en, src};
    endfunction

    function automatic logic [31:0] div_w(input logic [11:0] i, input logic [11:0] f);
        return {WR_KEY, i, f};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_now(input logic sel, output logic [31:0] d);
        rd_sel = sel;
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // measures n consecutive fall-to-fall intervals of clk_out, in system cycles
    task automatic measure(input int n, output int sum, output int mn,
                           output int mx, output int hi);
        logic prev;
        int cyc, got, hcnt, lim;
        sum = 0; mn = 1 << 30; mx = 0; hi = 0;
        prev = clk_out; lim = 0;
        while (!(prev && !clk_out) && lim < 4000) begin
            prev = clk_out; @(negedge clk); lim++;
        end
        cyc = 0; got = 0; hcnt = 0; prev = clk_out;
        while (got < n && lim < 8000) begin
            @(negedge clk); lim++; cyc++;
            if (clk_out) hcnt++;
            if (prev && !clk_out) begin
                sum += cyc;
                if (cyc < mn) mn = cyc;
                if (cyc > mx) mx = cyc;
                hi = hcnt; hcnt = 0; cyc = 0; got++;
            end
            prev = clk_out;
        end
    endtask

    task automatic stop_clean(input logic [3:0] src, input logic inv, input string req);
        logic [31:0] v;
        logic prev;
        int lim, bad;
        wr(0, ctl_w(src, 0, 0, inv, 0));
        lim = 0;
        prev = clk_out;
        rd_now(0, v);
        while (v[7] && lim < 3000) begin
            prev = clk_out;
            @(negedge clk); lim++;
            rd_now(0, v);
        end
        chk(v[7] == 0, req, "busy drops after disable", {31'd0, v[7]}, 0);
        chk(prev == ~inv && clk_out == inv, req, "busy drops with final edge",
            {30'd0, prev, clk_out}, {30'd0, ~inv, inv});
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (clk_out != inv) bad++;
        end
        chk(bad == 0, req, "output parked after stop", bad, 0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd_now(0, v);
        chk(v == 0, "R2", "control after reset", v, 0);
        rd_now(1, v);
        chk(v == 0, "R2", "divisor after reset", v, 0);
        chk(clk_out == 0, "R2", "output after reset", {31'd0, clk_out}, 0);
    endtask

    task automatic t_key;
        logic [31:0] v;
        wr(1, {8'h00, 12'd7, 12'd0});
        rd_now(1, v);
        chk(v == 0, "R1", "divisor write with bad key", v, 0);
        wr(1, div_w(12'd7, 12'h123));
        rd_now(1, v);
        chk(v == 32'h0000_7123, "R2", "divisor field positions", v, 32'h0000_7123);
        wr(0, {8'hA5, 13'd0, 2'b00, 1'b0, 2'b00, 1'b0, 1'b1, 4'd1});
        idle(2);
        rd_now(0, v);
        chk(v == 0, "R1", "control write with bad key", v, 0);
    endtask

    task automatic t_integer;
        logic [31:0] v;
        int s, mn, mx, hi;
        wr(1, div_w(12'd6, 12'h800));
        wr(0, ctl_w(1, 1, 0, 0, 0));
        rd_now(0, v);
        chk(v[7] == 0, "R11", "busy low one edge after enable", {31'd0, v[7]}, 0);
        @(negedge clk);
        rd_now(0, v);
        chk(v == 32'h0000_0091, "R11", "busy high two edges after enable", v, 32'h91);
        measure(4, s, mn, mx, hi);
        chk(s == 24 && mn == 6 && mx == 6, "R4", "order 0 ignores fraction", s, 24);
        chk(hi == 3, "R4", "even divisor high phase", hi, 3);
        stop_clean(1, 0, "R7");
        wr(1, div_w(12'd5, 12'h000));
        wr(0, ctl_w(1, 1, 0, 0, 0));
        measure(4, s, mn, mx, hi);
        chk(s == 20 && mn == 5 && mx == 5, "R4", "odd divisor period", s, 20);
        chk(hi == 2, "R4", "odd divisor high phase", hi, 2);
        stop_clean(1, 0, "R7");
    endtask

    task automatic t_small;
        int s, mn, mx, hi;
        for (int i = 0; i < 2; i++) begin
            wr(1, div_w(12'(i), 12'h000));
            wr(0, ctl_w(1, 1, 0, 0, 0));
            measure(4, s, mn, mx, hi);
            chk(s == 8 && mx == 2 && hi == 1, "R5", "tiny divisor acts as 2", s, 8);
            stop_clean(1, 0, "R5");
        end
    endtask

    task automatic t_frac;
        int s, mn, mx, hi;
        wr(1, div_w(12'd4, 12'h400));
        wr(0, ctl_w(1, 1, 0, 0, 1));
        measure(8, s, mn, mx, hi);
        chk(s == 34 && mn == 4 && mx == 5, "R6", "quarter fraction sum", s, 34);
        stop_clean(1, 0, "R6");
        wr(1, div_w(12'd4, 12'h800));
        wr(0, ctl_w(1, 1, 0, 0, 1));
        measure(8, s, mn, mx, hi);
        chk(s == 36 && mn == 4 && mx == 5, "R6", "half fraction sum", s, 36);
        stop_clean(1, 0, "R6");
        wr(0, ctl_w(1, 1, 0, 0, 3));
        measure(8, s, mn, mx, hi);
        chk(s == 36, "R6", "order 3 behaves as first order", s, 36);
        stop_clean(1, 0, "R6");
    endtask

    task automatic t_source;
        logic [31:0] v;
        int s, mn, mx, hi, bad;
        // R12: a source ticking every third cycle stretches each period threefold
        wr(1, div_w(12'd4, 12'h000));
        wr(0, ctl_w(2, 1, 0, 0, 0));
        measure(3, s, mn, mx, hi);
        chk(s == 36 && mn == 12 && mx == 12, "R3", "source 2 period in cycles", s, 36);
        stop_clean(2, 0, "R3");
        for (int sel = 0; sel < 10; sel += 9) begin
            wr(0, ctl_w(4'(sel), 1, 0, 0, 0));
            bad = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (clk_out) bad++;
            end
            rd_now(0, v);
            chk(bad == 0 && v[7] == 1, "R3", "silent source keeps output low", bad, 0);
            wr(0, ctl_w(4'(sel), 1, 1, 0, 0));
            rd_now(0, v);
            @(negedge clk);
            rd_now(0, v);
            chk(v[7] == 0 && clk_out == 0, "R8", "kill recovers silent source",
                {30'd0, v[7], clk_out}, 0);
            wr(0, ctl_w(1, 0, 0, 0, 0));
        end
    endtask

    task automatic t_kill;
        logic [31:0] v;
        int lim, bad;
        wr(1, div_w(12'd40, 12'h000));
        wr(0, ctl_w(1, 1, 0, 0, 0));
        lim = 0;
        while (!clk_out && lim < 200) begin @(negedge clk); lim++; end
        wr(0, ctl_w(1, 1, 1, 0, 0));
        @(negedge clk);
        rd_now(0, v);
        chk(v[7] == 0 && clk_out == 0, "R8", "kill during high phase",
            {30'd0, v[7], clk_out}, 0);
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            rd_now(0, v);
            if (v[7] || clk_out) bad++;
        end
        chk(bad == 0, "R8", "held kill keeps block stopped", bad, 0);
        wr(0, ctl_w(1, 1, 0, 0, 0));
        @(negedge clk);
        rd_now(0, v);
        chk(v[7] == 1, "R11", "restart after kill cleared", {31'd0, v[7]}, 1);
        stop_clean(1, 0, "R7");
    endtask

    task automatic t_guard;
        logic [31:0] v;
        wr(1, div_w(12'd6, 12'h000));
        wr(0, ctl_w(1, 1, 0, 0, 0));
        idle(3);
        wr(1, div_w(12'd9, 12'h055));
        rd_now(1, v);
        chk(v == 32'h0000_6000, "R9", "divisor frozen while busy", v, 32'h6000);
        wr(0, ctl_w(2, 1, 0, 1, 1));
        rd_now(0, v);
        chk(v[3:0] == 1 && v[10:9] == 0, "R9", "source and order frozen", v[10:0], 11'h1);
        chk(v[8] == 1 && v[4] == 1, "R9", "invert accepted while busy", {v[8], v[4]}, 2'b11);
        wr(0, ctl_w(1, 1, 0, 0, 0));
        stop_clean(1, 0, "R9");
        wr(1, div_w(12'd9, 12'h055));
        rd_now(1, v);
        chk(v == 32'h0000_9055, "R9", "divisor writable when idle", v, 32'h9055);
    endtask

    task automatic t_invert;
        int s, mn, mx, hi;
        wr(0, ctl_w(1, 0, 0, 1, 0));
        @(negedge clk);
        chk(clk_out == 1, "R10", "inverted idle level", {31'd0, clk_out}, 1);
        wr(1, div_w(12'd5, 12'h000));
        wr(0, ctl_w(1, 1, 0, 1, 0));
        measure(4, s, mn, mx, hi);
        chk(s == 20 && hi == 3, "R10", "inverted duty on divisor 5", hi, 3);
        stop_clean(1, 1, "R10");
        wr(0, ctl_w(1, 0, 0, 0, 0));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_key();
        t_integer();
        t_small();
        t_frac();
        t_source();
        t_kill();
        t_guard();
        t_invert();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule